// File: doc/BRIEF.md
# Shadowed Dual Compare with Reference Gating

This block is the compare stage for two extra channels of a PWM timer, channel 5 and channel 6. Each channel keeps a written compare value and an active compare value. The active value is compared against a shared up-counter, and the result drives that channel's reference waveform. The channel-5 control word also carries three gate-select bits. Each set bit masks the combined reference of one of channels 1, 2 and 3 with the channel-5 reference. The references of channels 1 to 3 come in as inputs, and the masked versions go out.

Software writes either control word through a one-cycle write strobe with a channel select. A per-channel preload enable decides when a write reaches the active copy: at the next clock edge, or at the next update-event pulse. The gate-select bits are shadowed the same way. Each gate bit follows the preload enable of the channel it masks. A read returns the written (preload) contents.

Top module: `dual_cmp_gate`

## Requirements
- R1: In the channel-5 word, bit 29 gates channel 1, bit 30 gates channel 2 and bit 31 gates channel 3. Bits 15:0 hold the compare value. Bits 28:16 are ignored on write and read as zero. Channel select 0 addresses channel 5 and 1 addresses channel 6.
- R2: While a channel's active gate bit is 0, its output equals its input reference.
- R3: While a channel's active gate bit is 1, its output is the AND of its input reference and the channel-5 reference.
- R4: With a channel's preload enable low, a written compare value becomes active at the clock edge that takes the write.
- R5: With the preload enable high, the active value holds until an update pulse, which copies the written value into it.
- R6: Each gate bit loads at once or on an update pulse, according to the preload enable of the channel it gates.
- R7: A channel reference is high while the counter is below its active compare value and low otherwise. An active value of zero keeps it low.
- R8: After reset, all compare and gate registers are zero, both references are low and no output is masked.
- R9: A write and an update pulse in the same cycle put the newly written value into the active register.
- R10: A read returns the preload contents of the selected word. Bits 31:16 of the channel-6 word read as zero.
- R11: Channel 6 has its own preload enable, and its compare loads independently of channel 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 channel 5, 1 channel 6 |
| wr_data | input | 32 | Write word |
| rd_sel | input | 1 | Read target: 0 channel 5, 1 channel 6 |
| rd_data | output | 32 | Preload contents of the selected word |
| upd_evt | input | 1 | Update-event pulse |
| pe_c5 | input | 1 | Preload enable, channel 5 compare |
| pe_c6 | input | 1 | Preload enable, channel 6 compare |
| pe_grp | input | 3 | Preload enables of channels 1..3 (bit 0 = channel 1) |
| cnt | input | 16 | Shared counter value |
| ref_in | input | 3 | References of channels 1..3 |
| ref_c5 | output | 1 | Channel-5 reference |
| ref_c6 | output | 1 | Channel-6 reference |
| ref_out | output | 3 | Combined references of channels 1..3 after gating |

## Verification
Every register in the block loads on the clock edge that takes the write or the update pulse. The references, masked outputs and read data are combinational from those registers and from the counter and reference inputs. A write or update therefore shows in the outputs one edge after it is presented. Counter and reference-input changes show in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, which places each check half a period after the edge that made the result due. Before each update pulse the bench checks that a preloaded value is still held back, and after the pulse it checks that the value has become active.

// File: rtl/dual_cmp_pkg.sv
package dual_cmp_pkg;
   typedef enum logic {
      SEL_C5 = 1'b0,
      SEL_C6 = 1'b1
   } word_sel_e;
endpackage

// File: rtl/cmp_shadow_chan.sv
module cmp_shadow_chan #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wd,
   input  logic          pe,
   input  logic          upd,
   input  logic [CW-1:0] cnt,
   output logic [CW-1:0] pre_q,
   output logic [CW-1:0] act_q,
   output logic          ref_o
);
   generate
      if (CW < 2) begin : g_bad_cw
         $error("cmp_shadow_chan: CW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (wr) begin
         pre_q <= wd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (wr && (!pe || upd)) begin
         act_q <= wd;
      end else if (pe && upd) begin
         act_q <= pre_q;
      end
   end

   assign ref_o = (cnt < act_q);

   p_direct_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !pe) |=> (act_q == $past(wd)));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pe && !upd) |=> $stable(act_q));
   p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pe && upd && !wr) |=> (act_q == $past(pre_q)));
   p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && upd) |=> (act_q == $past(wd)));
   p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == '0) |-> !ref_o);
endmodule

// File: rtl/grp_gate.sv
module grp_gate #(
   parameter int NG = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [NG-1:0] wd,
   input  logic [NG-1:0] pe,
   input  logic          upd,
   input  logic          ref_mask,
   input  logic [NG-1:0] ref_in,
   output logic [NG-1:0] pre_q,
   output logic [NG-1:0] act_q,
   output logic [NG-1:0] ref_out
);
   generate
      if (NG < 1) begin : g_bad_ng
         $error("grp_gate: NG must be at least 1");
      end
      for (genvar i = 0; i < NG; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q[i] <= 1'b0;
            end else if (wr) begin
               pre_q[i] <= wd[i];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q[i] <= 1'b0;
            end else if (wr && (!pe[i] || upd)) begin
               act_q[i] <= wd[i];
            end else if (pe[i] && upd) begin
               act_q[i] <= pre_q[i];
            end
         end

         assign ref_out[i] = ref_in[i] & (ref_mask | ~act_q[i]);

         p_gate_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pe[i] && !upd) |=> $stable(act_q[i]));
         p_masked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act_q[i] && !ref_mask) |-> !ref_out[i]);
         p_never_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !ref_in[i] |-> !ref_out[i]);
      end
   endgenerate
endmodule

// File: rtl/dual_cmp_gate.sv
module dual_cmp_gate
   import dual_cmp_pkg::*;
#(
   parameter int DW = 32,
   parameter int CW = 16,
   parameter int NG = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_sel,
   output logic [DW-1:0] rd_data,
   input  logic          upd_evt,
   input  logic          pe_c5,
   input  logic          pe_c6,
   input  logic [NG-1:0] pe_grp,
   input  logic [CW-1:0] cnt,
   input  logic [NG-1:0] ref_in,
   output logic          ref_c5,
   output logic          ref_c6,
   output logic [NG-1:0] ref_out
);
   localparam int NCH  = 2;
   localparam int GLSB = DW - NG;
   localparam int RSV  = DW - NG - CW;

   generate
      if (RSV < 0) begin : g_bad_layout
         $error("dual_cmp_gate: DW too small for gate bits plus compare");
      end
   endgenerate

   logic [NCH-1:0]          wr_ch;
   logic [NCH-1:0]          pe_ch;
   logic [NCH-1:0]          ref_ch;
   logic [NCH-1:0][CW-1:0]  pre_ch;
   logic [NCH-1:0][CW-1:0]  act_ch;
   logic [NG-1:0]           grp_pre;
   logic [NG-1:0]           grp_act;

   assign pe_ch = {pe_c6, pe_c5};

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chan
         assign wr_ch[g] = wr_en && (wr_sel == g[0]);
         cmp_shadow_chan #(.CW(CW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_ch[g]),
            .wd    (wr_data[CW-1:0]),
            .pe    (pe_ch[g]),
            .upd   (upd_evt),
            .cnt   (cnt),
            .pre_q (pre_ch[g]),
            .act_q (act_ch[g]),
            .ref_o (ref_ch[g])
         );
      end
   endgenerate

   grp_gate #(.NG(NG)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ch[SEL_C5]),
      .wd       (wr_data[DW-1:GLSB]),
      .pe       (pe_grp),
      .upd      (upd_evt),
      .ref_mask (ref_ch[SEL_C5]),
      .ref_in   (ref_in),
      .pre_q    (grp_pre),
      .act_q    (grp_act),
      .ref_out  (ref_out)
   );

   assign ref_c5 = ref_ch[SEL_C5];
   assign ref_c6 = ref_ch[SEL_C6];

   always_comb begin
      rd_data = '0;
      if (rd_sel == SEL_C5) begin
         rd_data[DW-1:GLSB] = grp_pre;
         rd_data[CW-1:0]    = pre_ch[SEL_C5];
      end else begin
         rd_data[CW-1:0]    = pre_ch[SEL_C6];
      end
   end

   p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[GLSB-1:CW] == '0);
   p_c6_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_C6) |-> (rd_data[DW-1:CW] == '0));
   p_c6_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_C6) |=> $stable(act_ch[SEL_C5]));
endmodule

// File: tb/dual_cmp_gate_bench.sv
module dual_cmp_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        upd_evt = 1'b0;
   logic        pe_c5 = 1'b0;
   logic        pe_c6 = 1'b0;
   logic [2:0]  pe_grp = '0;
   logic [15:0] cnt = '0;
   logic [2:0]  ref_in = 3'b111;
   logic        ref_c5, ref_c6;
   logic [2:0]  ref_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dual_cmp_gate u_dual_cmp_gate (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .upd_evt(upd_evt), .pe_c5(pe_c5), .pe_c6(pe_c6), .pe_grp(pe_grp),
      .cnt(cnt), .ref_in(ref_in), .ref_c5(ref_c5), .ref_c6(ref_c6),
      .ref_out(ref_out)
   );

   // {cnt, ref_in, expected ref_c5, expected ref_out}; active ch5 = 0x0100, gates ch1+ch3
   localparam logic [22:0] TBL [8] = '{
      {16'h0000, 3'b111, 1'b1, 3'b111},
      {16'h00FF, 3'b111, 1'b1, 3'b111},
      {16'h0100, 3'b111, 1'b0, 3'b010},
      {16'hFFFF, 3'b011, 1'b0, 3'b010},
      {16'h0050, 3'b010, 1'b1, 3'b010},
      {16'h0200, 3'b100, 1'b0, 3'b000},
      {16'h0200, 3'b000, 1'b0, 3'b000},
      {16'h0001, 3'b101, 1'b1, 3'b101}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic sel, input logic [31:0] d, input logic with_upd);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d; upd_evt = with_upd;
      @(negedge clk);
      wr_en = 1'b0; upd_evt = 1'b0;
   endtask

   task automatic pulse_upd();
      @(negedge clk);
      upd_evt = 1'b1;
      @(negedge clk);
      upd_evt = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 ref_c5", {31'd0, ref_c5}, 32'd0);
      chk("R8 ref_c6", {31'd0, ref_c6}, 32'd0);
      chk("R8 ref_out", {29'd0, ref_out}, 32'd7);
      rd_sel = 1'b0; #0.1;
      chk("R8 rd c5", rd_data, 32'd0);
      rd_sel = 1'b1; #0.1;
      chk("R8 rd c6", rd_data, 32'd0);

      // R4 direct load, R1 gates ch1 and ch3
      wr_word(1'b0, 32'hA000_0100, 1'b0);
      for (int k = 0; k < 8; k++) begin
         cnt = TBL[k][22:7]; ref_in = TBL[k][6:4];
         @(negedge clk);
         chk("R7 R4 ref_c5 table", {31'd0, ref_c5}, {31'd0, TBL[k][3]});
         chk("R2 R3 R1 ref_out table", {29'd0, ref_out}, {29'd0, TBL[k][2:0]});
      end

      // R7 channel 6 compare, R4
      wr_word(1'b1, 32'h0000_0040, 1'b0);
      cnt = 16'h0030; @(negedge clk);
      chk("R7 ref_c6 below", {31'd0, ref_c6}, 32'd1);
      cnt = 16'h0040; @(negedge clk);
      chk("R7 ref_c6 equal", {31'd0, ref_c6}, 32'd0);

      // R5 preload hold then copy
      pe_c5 = 1'b1; cnt = 16'h0090;
      wr_word(1'b0, 32'hA000_0080, 1'b0);
      chk("R5 held before update", {31'd0, ref_c5}, 32'd1);
      rd_sel = 1'b0; #0.1;
      chk("R10 read preload", rd_data, 32'hA000_0080);
      pulse_upd();
      chk("R5 copied on update", {31'd0, ref_c5}, 32'd0);

      // R9 write and update same cycle
      wr_word(1'b0, 32'hA000_0200, 1'b1);
      chk("R9 same-cycle load", {31'd0, ref_c5}, 32'd1);

      // R11 channel 6 own preload enable
      pe_c6 = 1'b1; cnt = 16'h0030;
      wr_word(1'b1, 32'h0000_0010, 1'b0);
      chk("R11 ch6 held", {31'd0, ref_c6}, 32'd1);
      chk("R11 ch5 unaffected", {31'd0, ref_c5}, 32'd1);
      pulse_upd();
      chk("R11 ch6 after update", {31'd0, ref_c6}, 32'd0);

      // R6 gate bits follow gated channel's preload enable
      pe_grp = 3'b001; cnt = 16'hFFFF; ref_in = 3'b111;
      wr_word(1'b0, 32'h4000_0200, 1'b0);
      chk("R6 ch1 pending, ch2 ch3 immediate", {29'd0, ref_out}, 32'd4);
      pulse_upd();
      chk("R6 ch1 after update", {29'd0, ref_out}, 32'd5);

      // R1 reserved bits, R10 channel 6 upper bits
      wr_word(1'b0, 32'h1FFF_0123, 1'b0);
      rd_sel = 1'b0; #0.1;
      chk("R1 reserved read zero", rd_data, 32'h0000_0123);
      wr_word(1'b1, 32'hFFFF_FFFF, 1'b0);
      rd_sel = 1'b1; #0.1;
      chk("R10 ch6 upper zero", rd_data, 32'h0000_FFFF);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule